// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept. The receive path presents the 48-bit destination address with a one-cycle valid strobe, along with a runt flag and an error flag for the frame. The filter compares the address against a programmable station address. It also classifies the address as broadcast, multicast or an own-address match. It then combines these classes with a six-bit accept-control word to produce an accept decision.

The result appears one cycle after the strobe. It consists of an accept pulse and a 16-bit status fragment that carries the three match-type flags in the bit positions the per-frame status word uses. The station address is loaded as two 32-bit little-endian words. Hash-based multicast filtering is not modelled: every multicast frame counts as a multicast match.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, the accept-control word reads 0x0A (own-address and broadcast acceptance only). The station address reads all zeros, and result_valid_o, accept_o and status_o are all zero.
- R2: A write with ctl_wr_i loads ctl_i into the accept-control word, and ctl_o shows the new value from the next cycle. The bit meanings are: bit 0 accept-all, bit 1 own-address, bit 2 multicast, bit 3 broadcast, bit 4 accept runt, bit 5 accept errored.
- R3: A station write with sta_sel_i=0 loads address bytes 0..3 from sta_data_i[7:0], [15:8], [23:16] and [31:24]. With sta_sel_i=1 it loads bytes 4 and 5 from sta_data_i[7:0] and [15:8], and sta_data_i[31:16] is ignored. sta_o holds byte n in bits [8n+7:8n], and dst_addr_i uses the same byte layout.
- R4: A destination of all ones sets status_o bit 13 (broadcast).
- R5: A destination whose byte 0 has bit 0 set, and which is not all ones, sets status_o bit 15 (multicast).
- R6: A destination equal to the station address sets status_o bit 14 (own-address match). All other bits of status_o are always zero.
- R7: Ignoring the runt and error flags, a frame is accepted when accept-all is set, or when one of its match types has its enable bit set. Toggling bit 0 alone enters and leaves promiscuous acceptance.
- R8: A frame flagged runt is accepted only if accept-runt (bit 4) is set.
- R9: A frame flagged errored is accepted only if accept-errored (bit 5) is set.
- R10: result_valid_o, accept_o and status_o are registered and appear exactly one cycle after dst_valid_i. In any cycle without a result, all three are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Load the accept-control word |
| ctl_i | input | 6 | New accept-control word |
| sta_wr_i | input | 1 | Load one station address word |
| sta_sel_i | input | 1 | Station word select (0: bytes 0..3, 1: bytes 4..5) |
| sta_data_i | input | 32 | Station address word data |
| dst_valid_i | input | 1 | Destination address and flags are valid |
| dst_addr_i | input | 48 | Frame destination address, byte n at [8n+7:8n] |
| runt_i | input | 1 | Frame is a runt |
| err_i | input | 1 | Frame has a receive error |
| ctl_o | output | 6 | Current accept-control word |
| sta_o | output | 48 | Current station address |
| result_valid_o | output | 1 | Filter result valid |
| accept_o | output | 1 | Frame accepted |
| status_o | output | 16 | Match flags: bit 13 broadcast, bit 14 own address, bit 15 multicast |

## Verification
Every frame result is due in the cycle after its strobe. The bench raises dst_valid_i on a falling edge and samples the outputs on the following falling edge, after exactly one rising edge has passed. It then samples once more, one cycle later, to confirm that the result has cleared. Control and station writes become visible at ctl_o and sta_o one cycle after the write, and the bench samples them at that same offset. The sweep covers all 64 control words, against four address classes and all four runt/error combinations.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int WORD_W     = 32;
  localparam int STAT_W     = 16;
  localparam int BCAST_BIT  = 13;
  localparam int PHYS_BIT   = 14;
  localparam int MCAST_BIT  = 15;

  typedef struct packed {
    logic take_err;
    logic take_runt;
    logic take_bcast;
    logic take_mcast;
    logic take_phys;
    logic take_all;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{take_err: 1'b0, take_runt: 1'b0, take_bcast: 1'b1,
                                 take_mcast: 1'b0, take_phys: 1'b1, take_all: 1'b0};
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int N_BYTES = ADDR_BYTES,
  parameter int DATA_W  = WORD_W,
  localparam int LANES  = DATA_W / 8,
  localparam int N_WORDS = (N_BYTES + LANES - 1) / LANES,
  localparam int SEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctl_wr_i,
  input  ctl_t                 ctl_i,
  input  logic                 sta_wr_i,
  input  logic [SEL_W-1:0]     sta_sel_i,
  input  logic [DATA_W-1:0]    sta_data_i,
  output ctl_t                 ctl_o,
  output logic [N_BYTES*8-1:0] sta_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= CTL_RESET;
    else if (ctl_wr_i) ctl_q <= ctl_i;
  end
  assign ctl_o = ctl_q;

  // one byte register per address byte, word/lane from its index
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    localparam int WIDX = b / LANES;
    localparam int LANE = b % LANES;
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (sta_wr_i && (int'(sta_sel_i) == WIDX))
        byte_q <= sta_data_i[LANE*8 +: 8];
    end
    assign sta_o[b*8 +: 8] = byte_q;
  end

  assert_ctl_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |=> (ctl_o == $past(ctl_i)));
  assert_ctl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i |=> $stable(ctl_o));
  assert_sta_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sta_wr_i |=> $stable(sta_o));
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int N_BYTES = ADDR_BYTES,
  localparam int AW = N_BYTES * 8
) (
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] sta_i,
  output logic          bcast_o,
  output logic          mcast_o,
  output logic          phys_o
);
  logic [N_BYTES-1:0] byte_eq;
  logic [N_BYTES-1:0] byte_ones;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_cmp
    assign byte_eq[b]   = (dst_i[b*8 +: 8] == sta_i[b*8 +: 8]);
    assign byte_ones[b] = &dst_i[b*8 +: 8];
  end

  always_comb begin
    bcast_o = &byte_ones;
    // group bit is the first transmitted bit: bit 0 of byte 0
    mcast_o = dst_i[0] && !bcast_o;
    phys_o  = &byte_eq;
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dst_valid_i,
  input  logic              dst_grp_i,
  input  logic              runt_i,
  input  logic              err_i,
  input  logic              bcast_i,
  input  logic              mcast_i,
  input  logic              phys_i,
  input  ctl_t              ctl_i,
  output logic              result_valid_o,
  output logic              accept_o,
  output logic [STAT_W-1:0] status_o
);
  logic hit, allow, take_d;
  logic [STAT_W-1:0] stat_d;

  always_comb begin
    hit    = ctl_i.take_all
           | (ctl_i.take_phys  & phys_i)
           | (ctl_i.take_mcast & mcast_i)
           | (ctl_i.take_bcast & bcast_i);
    allow  = (!runt_i || ctl_i.take_runt) && (!err_i || ctl_i.take_err);
    take_d = hit && allow;
    stat_d = '0;
    stat_d[BCAST_BIT] = bcast_i;
    stat_d[PHYS_BIT]  = phys_i;
    stat_d[MCAST_BIT] = mcast_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      accept_o       <= 1'b0;
      status_o       <= '0;
    end else if (dst_valid_i) begin
      result_valid_o <= 1'b1;
      accept_o       <= take_d;
      status_o       <= stat_d;
    end else begin
      result_valid_o <= 1'b0;
      accept_o       <= 1'b0;
      status_o       <= '0;
    end
  end

  assert_result_timing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_i |=> result_valid_o);
  assert_idle_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dst_valid_i |=> (!result_valid_o && !accept_o && status_o == '0));
  assert_bcast_mcast_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[BCAST_BIT] && status_o[MCAST_BIT]));
  assert_mcast_needs_grp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && !dst_grp_i) |=> !status_o[MCAST_BIT]);
  assert_runt_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && runt_i && !ctl_i.take_runt) |=> !accept_o);
  assert_err_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && err_i && !ctl_i.take_err) |=> !accept_o);
  assert_promisc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && ctl_i.take_all && !runt_i && !err_i) |=> accept_o);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [5:0]        ctl_i,
  input  logic              sta_wr_i,
  input  logic              sta_sel_i,
  input  logic [WORD_W-1:0] sta_data_i,
  input  logic              dst_valid_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic              runt_i,
  input  logic              err_i,
  output logic [5:0]        ctl_o,
  output logic [ADDR_W-1:0] sta_o,
  output logic              result_valid_o,
  output logic              accept_o,
  output logic [STAT_W-1:0] status_o
);
  ctl_t ctl_q;
  logic [ADDR_W-1:0] sta_q;
  logic bcast, mcast, phys;

  rxf_cfg_regs #(.N_BYTES(ADDR_BYTES), .DATA_W(WORD_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_i      (ctl_t'(ctl_i)),
    .sta_wr_i   (sta_wr_i),
    .sta_sel_i  (sta_sel_i),
    .sta_data_i (sta_data_i),
    .ctl_o      (ctl_q),
    .sta_o      (sta_q)
  );

  rxf_classify #(.N_BYTES(ADDR_BYTES)) u_cls (
    .dst_i   (dst_addr_i),
    .sta_i   (sta_q),
    .bcast_o (bcast),
    .mcast_o (mcast),
    .phys_o  (phys)
  );

  rxf_decide u_dec (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dst_valid_i    (dst_valid_i),
    .dst_grp_i      (dst_addr_i[0]),
    .runt_i         (runt_i),
    .err_i          (err_i),
    .bcast_i        (bcast),
    .mcast_i        (mcast),
    .phys_i         (phys),
    .ctl_i          (ctl_q),
    .result_valid_o (result_valid_o),
    .accept_o       (accept_o),
    .status_o       (status_o)
  );

  assign ctl_o = ctl_q;
  assign sta_o = sta_q;
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [5:0]  ctl = '0;
  logic        sta_wr = 1'b0;
  logic        sta_sel = 1'b0;
  logic [31:0] sta_data = '0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst = '0;
  logic        runt = 1'b0;
  logic        err = 1'b0;
  logic [5:0]  ctl_q;
  logic [47:0] sta_q;
  logic        rvalid, acc;
  logic [15:0] stat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [47:0] MY_ADDR = 48'h5E4D_3C2B_1A02;

  always #4 clk = ~clk;

  rx_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_i(ctl),
    .sta_wr_i(sta_wr), .sta_sel_i(sta_sel), .sta_data_i(sta_data),
    .dst_valid_i(dst_valid), .dst_addr_i(dst), .runt_i(runt), .err_i(err),
    .ctl_o(ctl_q), .sta_o(sta_q), .result_valid_o(rvalid), .accept_o(acc),
    .status_o(stat)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [5:0] v);
    ctl_wr = 1'b1; ctl = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic write_sta(input logic sel, input logic [31:0] v);
    sta_wr = 1'b1; sta_sel = sel; sta_data = v;
    @(negedge clk);
    sta_wr = 1'b0;
  endtask

  // drive one frame, return {valid, accept, status} one cycle later
  task automatic frame(input logic [47:0] a, input logic r, input logic e,
                       output logic [17:0] res);
    dst_valid = 1'b1; dst = a; runt = r; err = e;
    @(negedge clk);
    dst_valid = 1'b0; dst = '0; runt = 1'b0; err = 1'b0;
    res = {rvalid, acc, stat};
  endtask

  function automatic logic [17:0] model(input logic [5:0] c, input logic [47:0] a,
                                        input logic r, input logic e);
    logic b, m, p, k;
    logic [15:0] s;
    b = (a == '1);
    m = a[0] && !b;
    p = (a == MY_ADDR);
    k = (c[0] | (c[1] & p) | (c[2] & m) | (c[3] & b)) & (!r | c[4]) & (!e | c[5]);
    s = '0; s[13] = b; s[14] = p; s[15] = m;
    return {1'b1, k, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [17:0] res;
    logic [47:0] kinds [4];
    kinds[0] = 48'hFFFF_FFFF_FFFF;   // broadcast
    kinds[1] = MY_ADDR;              // own address
    kinds[2] = 48'h0100_005E_0001;   // multicast
    kinds[3] = 48'h5E4D_3C2B_1A06;   // other unicast
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctl reset", 64'(ctl_q), 64'h0A);
    check("R1 sta reset", 64'(sta_q), 64'h0);
    check("R1 outputs reset", 64'({rvalid, acc, stat}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset config accepts broadcast only (station zero, not matched)
    frame(kinds[0], 1'b0, 1'b0, res);
    check("R1 bcast after reset", 64'(res), 64'(model(6'h0A, kinds[0], 0, 0)));
    frame(kinds[2], 1'b0, 1'b0, res);
    check("R1 mcast after reset", 64'(res[16]), 64'h0);
    // R3 station load, upper half of word 1 ignored
    write_sta(1'b0, 32'h3C2B_1A02);
    check("R3 word0", 64'(sta_q), 64'h0000_3C2B_1A02);
    write_sta(1'b1, 32'hDEAD_5E4D);
    check("R3 word1 upper ignored", 64'(sta_q), 64'(MY_ADDR));
    // R10 result clears a cycle later
    frame(kinds[1], 1'b0, 1'b0, res);
    check("R6 own match at reset cfg", 64'(res), 64'(model(6'h0A, kinds[1], 0, 0)));
    @(negedge clk);
    check("R10 result cleared", 64'({rvalid, acc, stat}), 64'h0);
    // R2/R4..R9 sweep
    for (int c = 0; c < 64; c++) begin
      write_ctl(6'(c));
      check("R2 ctl readback", 64'(ctl_q), 64'(c));
      for (int k = 0; k < 4; k++) begin
        for (int re = 0; re < 4; re++) begin
          frame(kinds[k], re[0], re[1], res);
          if (re[0])      check("R8 runt gating",   64'(res), 64'(model(6'(c), kinds[k], 1, re[1])));
          else if (re[1]) check("R9 error gating",  64'(res), 64'(model(6'(c), kinds[k], 0, 1)));
          else if (k == 0) check("R4 broadcast",    64'(res), 64'(model(6'(c), kinds[k], 0, 0)));
          else if (k == 1) check("R6 own address",  64'(res), 64'(model(6'(c), kinds[k], 0, 0)));
          else if (k == 2) check("R5 multicast",    64'(res), 64'(model(6'(c), kinds[k], 0, 0)));
          else             check("R7 unicast other", 64'(res), 64'(model(6'(c), kinds[k], 0, 0)));
        end
      end
    end
    // R7 promiscuous by toggling bit 0 alone
    write_ctl(6'h0A);
    frame(kinds[3], 1'b0, 1'b0, res);
    check("R7 promisc off", 64'(res[16]), 64'h0);
    write_ctl(6'h0B);
    frame(kinds[3], 1'b0, 1'b0, res);
    check("R7 promisc on", 64'(res[16]), 64'h1);
    write_ctl(6'h0A);
    frame(kinds[3], 1'b0, 1'b0, res);
    check("R7 promisc left", 64'(res[16]), 64'h0);
    // R10 back-to-back strobes each give a result
    dst_valid = 1'b1; dst = kinds[0];
    @(negedge clk);
    check("R10 first of pair", 64'({rvalid, acc}), 64'h3);
    dst = kinds[3];
    @(negedge clk);
    dst_valid = 1'b0;
    check("R10 second of pair", 64'({rvalid, acc, stat}), 64'(model(6'h0A, kinds[3], 0, 0)));
    @(negedge clk);
    check("R10 idle after pair", 64'(rvalid), 64'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule